// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block is a bit-serial master for a three-wire serial EEPROM organised as 64 words of 16 bits. When it receives a start pulse, it reads the whole device, one word after another. Each address gets its own read command. Between two words the chip select is released and one extra clock pulse is given. A continuous streaming read is not used.

For each word, the block shifts out a 9-bit command. It then checks that the device answers with a leading zero, and then shifts in 16 data bits. Every word it reads is presented for one cycle with its address. A one-cycle done pulse closes a complete pass. If the device fails to give its leading zero, the pass ends at once with a one-cycle error pulse, and the address that failed is shown with it. The serial clock phases are timed in system clocks through a parameter, so the same block can serve different clock rates.

Top module: `mw_eeprom_scanner`

## Requirements
- R1: While reset is high, and after reset is released, chip select, serial clock, serial data out and every strobe and bus output are low. A reset applied during a pass stops it within one clock.
- R2: Each command is 9 bits, sent most significant bit first with chip select high: a 1, then the read code 1,0, then the 6-bit address. The value is 0x180 OR address. Data out and chip select do not change on a system clock where the serial clock rises.
- R3: Every high phase of the serial clock lasts exactly HALF_CYC system clocks, and every low phase lasts at least HALF_CYC.
- R4: After the ninth command bit, data in is sampled at the end of one low phase of HALF_CYC clocks. If it is 1, the pass ends: error pulses for one cycle, word_addr shows the failing address, chip select is already low, and no further word of that pass is delivered.
- R5: Each word is built from 16 bits, most significant first, each sampled on the system clock where its serial clock high phase ends. word_valid pulses for one cycle with word_data and word_addr. At most one of word_valid, done and error is high in any cycle.
- R6: Each command is followed by one data word. After each word, chip select goes low and exactly one serial clock pulse is given with chip select low, before the next command.
- R7: A full pass reads addresses 0 to 63 in increasing order. done pulses for one cycle after the trailing clock pulse of word 63.
- R8: After done or error, all outputs stay low until the next start.
- R9: A start pulse during a pass has no effect. The pass continues in order and delivers 64 words.
- R10: A start that is high in the cycle where done is high is accepted. Chip select rises in the next cycle, and a new pass begins at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a full pass when idle |
| ee_sel | output | 1 | EEPROM chip select, active high |
| ee_clk | output | 1 | EEPROM serial clock |
| ee_mosi | output | 1 | Serial data toward the EEPROM |
| ee_miso | input | 1 | Serial data from the EEPROM |
| word_valid | output | 1 | One-cycle strobe for a word that has been read |
| word_addr | output | 6 | Address of the strobed word, or of the failing word with error |
| word_data | output | 16 | Word that has been read |
| done | output | 1 | One-cycle strobe at the end of a full pass |
| error | output | 1 | One-cycle strobe when the leading zero is missing |

## Verification
The done strobe of one pass and the acceptance of the start for the next pass can fall in the same cycle. This is provoked by holding start high through a whole pass, so that every start seen while busy is ignored and the one seen in the done cycle is taken. It is judged at the ports: chip select must be low in the done cycle and high one cycle later. The second pass must then deliver all 64 words in order, starting again at address 0.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CHK,
        ST_DATA,
        ST_STOP
    } mwr_state_e;

    typedef struct packed {
        logic cs;
        logic sk;
        logic di;
    } mwr_pins_t;

    localparam logic       START_BIT = 1'b1;
    localparam logic [1:0] OP_READ   = 2'b10;
    localparam int         OPC_W     = 2;

    // start bit, opcode and address packed right-aligned into 32 bits
    function automatic logic [31:0] mwr_read_cmd(input logic [15:0] addr, input int aw);
        logic [31:0] r;
        r = 32'(addr);
        r = r | (32'(OP_READ) << aw);
        r = r | (32'(START_BIT) << (aw + OPC_W));
        return r;
    endfunction

    function automatic int mwr_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mwr_phase_timer.sv
module mwr_phase_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic phase_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign phase_end = run && (cnt == LAST);

    // a running phase always ends within HALF_CYC clocks
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(phase_end)) |-> (cnt == '0 || HALF_CYC == 1)); // R3

endmodule

// File: rtl/mwr_shift_unit.sv
module mwr_shift_unit #(
    parameter int CMD_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CMD_W-1:0]  load_val,
    input  logic              shift_cmd,
    input  logic              capture,
    input  logic              din,
    output logic              cmd_bit,
    output logic [DATA_W-1:0] word_next
);
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= load_val;
        end else if (shift_cmd) begin
            cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            word_q <= '0;
        end else if (capture) begin
            word_q <= word_next;
        end
    end

    assign cmd_bit   = cmd_q[CMD_W-1];
    assign word_next = {word_q[DATA_W-2:0], din};

    // after a reload the first bit shown is the start bit
    AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
        load |=> (cmd_bit == START_BIT_OF(load_val)));

    function automatic logic START_BIT_OF(input logic [CMD_W-1:0] v);
        return v[CMD_W-1];
    endfunction

endmodule

// File: rtl/mwr_seq_ctrl.sv
module mwr_seq_ctrl
    import mwr_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int DATA_W    = 16,
    parameter int AW        = 6,
    parameter int CMD_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              din,
    input  logic              phase_end,
    input  logic              cmd_bit,
    input  logic [DATA_W-1:0] word_next,
    output logic              timer_run,
    output logic              cmd_load,
    output logic [CMD_W-1:0]  cmd_val,
    output logic              cmd_shift,
    output logic              capture,
    output mwr_pins_t         pins,
    output logic              word_valid,
    output logic [AW-1:0]     word_addr,
    output logic [DATA_W-1:0] word_data,
    output logic              done,
    output logic              error
);
    localparam int BCW = $clog2(mwr_max(CMD_W, DATA_W));
    localparam logic [BCW-1:0] LAST_CMD  = BCW'(CMD_W - 1);
    localparam logic [BCW-1:0] LAST_DAT  = BCW'(DATA_W - 1);
    localparam logic [AW-1:0]  LAST_ADDR = AW'(NUM_WORDS - 1);

    mwr_state_e        st;
    logic              phase;
    logic [BCW-1:0]    bitcnt;
    logic [AW-1:0]     addr;
    logic [AW-1:0]     next_addr;
    logic              lo_end, hi_end, last_word;

    logic              v_q, done_q, err_q;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        timer_run = (st != ST_IDLE);
        lo_end    = phase_end && !phase;
        hi_end    = phase_end && phase;
        last_word = (addr == LAST_ADDR);
        cmd_shift = (st == ST_CMD) && hi_end;
        capture   = (st == ST_DATA) && hi_end;
        cmd_load  = ((st == ST_IDLE) && start) ||
                    ((st == ST_STOP) && hi_end && !last_word);
        next_addr = (st == ST_IDLE) ? '0 : addr + 1'b1;
        cmd_val   = CMD_W'(mwr_read_cmd(16'(next_addr), AW));
        pins.cs   = (st == ST_CMD) || (st == ST_CHK) || (st == ST_DATA);
        pins.sk   = phase && ((st == ST_CMD) || (st == ST_DATA) || (st == ST_STOP));
        pins.di   = (st == ST_CMD) && cmd_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            phase  <= 1'b0;
            bitcnt <= '0;
            addr   <= '0;
            v_q    <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            v_q    <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st     <= ST_CMD;
                        addr   <= '0;
                        bitcnt <= '0;
                        phase  <= 1'b0;
                    end
                end
                ST_CMD: begin
                    if (lo_end) begin
                        phase <= 1'b1;
                    end else if (hi_end) begin
                        phase <= 1'b0;
                        if (bitcnt == LAST_CMD) begin
                            bitcnt <= '0;
                            st     <= ST_CHK;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_CHK: begin
                    if (lo_end) begin
                        if (din) begin
                            st     <= ST_IDLE;
                            err_q  <= 1'b1;
                            addr_q <= addr;
                        end else begin
                            st <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (lo_end) begin
                        phase <= 1'b1;
                    end else if (hi_end) begin
                        phase <= 1'b0;
                        if (bitcnt == LAST_DAT) begin
                            bitcnt <= '0;
                            st     <= ST_STOP;
                            v_q    <= 1'b1;
                            addr_q <= addr;
                            data_q <= word_next;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (lo_end) begin
                        phase <= 1'b1;
                    end else if (hi_end) begin
                        phase <= 1'b0;
                        if (last_word) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            addr <= addr + 1'b1;
                            st   <= ST_CMD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign word_valid = v_q;
    assign word_addr  = addr_q;
    assign word_data  = data_q;
    assign done       = done_q;
    assign error      = err_q;

    AST_RISE_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(pins.sk) |-> ($stable(pins.cs) && $stable(pins.di))); // R2
    AST_ERR_NEEDS_ONE: assert property (@(posedge clk) disable iff (rst)
        error |-> $past(din)); // R4
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        error |-> (!pins.cs && !pins.sk && !pins.di)); // R4
    AST_WORD_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (!pins.cs && !pins.sk)); // R6
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_valid, done, error})); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!pins.cs && !pins.sk && !pins.di && word_addr == '0)); // R7

endmodule

// File: rtl/mw_eeprom_scanner.sv
module mw_eeprom_scanner
    import mwr_pkg::*;
#(
    parameter  int NUM_WORDS = 64,
    parameter  int DATA_W    = 16,
    parameter  int HALF_CYC  = 4,
    localparam int AW        = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              ee_sel,
    output logic              ee_clk,
    output logic              ee_mosi,
    input  logic              ee_miso,
    output logic              word_valid,
    output logic [AW-1:0]     word_addr,
    output logic [DATA_W-1:0] word_data,
    output logic              done,
    output logic              error
);
    localparam int CMD_W = 1 + OPC_W + AW;

    logic              timer_run, phase_end;
    logic              cmd_load, cmd_shift, capture, cmd_bit;
    logic [CMD_W-1:0]  cmd_val;
    logic [DATA_W-1:0] word_next;
    mwr_pins_t         pins;

    mwr_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (timer_run),
        .phase_end (phase_end)
    );

    mwr_shift_unit #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd_load),
        .load_val  (cmd_val),
        .shift_cmd (cmd_shift),
        .capture   (capture),
        .din       (ee_miso),
        .cmd_bit   (cmd_bit),
        .word_next (word_next)
    );

    mwr_seq_ctrl #(
        .NUM_WORDS (NUM_WORDS),
        .DATA_W    (DATA_W),
        .AW        (AW),
        .CMD_W     (CMD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .din        (ee_miso),
        .phase_end  (phase_end),
        .cmd_bit    (cmd_bit),
        .word_next  (word_next),
        .timer_run  (timer_run),
        .cmd_load   (cmd_load),
        .cmd_val    (cmd_val),
        .cmd_shift  (cmd_shift),
        .capture    (capture),
        .pins       (pins),
        .word_valid (word_valid),
        .word_addr  (word_addr),
        .word_data  (word_data),
        .done       (done),
        .error      (error)
    );

    assign ee_sel  = pins.cs;
    assign ee_clk  = pins.sk;
    assign ee_mosi = pins.di;

    AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        ((done || error) && !start) |=> (!ee_sel && !ee_clk && !ee_mosi &&
                                          !word_valid && !done && !error &&
                                          word_addr == '0 && word_data == '0)); // R8
    AST_RESTART_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> ee_sel); // R10

endmodule

// File: tb/test_mw_eeprom_scanner.sv
module test_mw_eeprom_scanner;
    localparam int HALF = 4;
    localparam int NW   = 64;
    localparam int DW   = 16;
    localparam int AW   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic ee_sel, ee_clk, ee_mosi, ee_miso;
    logic word_valid, done, error;
    logic [AW-1:0] word_addr;
    logic [DW-1:0] word_data;

    always #4 clk = ~clk;

    mw_eeprom_scanner #(.NUM_WORDS(NW), .DATA_W(DW), .HALF_CYC(HALF)) i_mw_eeprom_scanner (
        .clk(clk), .rst(rst), .start(start),
        .ee_sel(ee_sel), .ee_clk(ee_clk), .ee_mosi(ee_mosi), .ee_miso(ee_miso),
        .word_valid(word_valid), .word_addr(word_addr), .word_data(word_data),
        .done(done), .error(error)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input int a);
        return 16'hC3A5 ^ 16'(a * 1033);
    endfunction

    // ---------------- behavioural EEPROM ----------------
    bit   inj_en   = 1'b0;
    int   inj_addr = 0;
    logic mdo = 1'b1;
    int   m_edges = 0;
    logic [8:0] m_cmd = '0;
    int   m_exp_addr = 0;
    int   cmd_bad = 0, cmd_seen = 0, sess_bad = 0, stop_cnt = 0;

    assign ee_miso = mdo;

    always @(posedge ee_clk) begin
        if (!ee_sel) begin
            stop_cnt++;
        end else begin
            logic [15:0] w;
            m_edges++;
            if (m_edges <= 9) m_cmd = {m_cmd[7:0], ee_mosi};
            if (m_edges == 9) begin
                cmd_seen++;
                if (m_cmd != (9'h180 | 9'(m_exp_addr))) cmd_bad++;
                mdo = (inj_en && m_cmd[5:0] == 6'(inj_addr)) ? 1'b1 : 1'b0;
            end else if (m_edges >= 10 && m_edges <= 25) begin
                w = mem_word(int'(m_cmd[5:0]));
                mdo = w[25 - m_edges];
            end
        end
    end

    always @(negedge ee_sel) begin
        if (rst) begin
            m_exp_addr = 0;
        end else begin
            if (!(m_edges == 25 || (m_edges == 9 && inj_en))) sess_bad++;
            if (m_edges == 25) m_exp_addr = (m_exp_addr + 1) % NW;
            else m_exp_addr = 0;
        end
        m_edges = 0;
        mdo = 1'b1;
    end

    // ---------------- output monitors ----------------
    logic start_seen = 1'b0;
    always @(posedge clk) start_seen <= start;

    int exp_addr = 0, nwords = 0, run_words = 0, word_bad = 0, idle_bad = 0;
    int skw = 0, skw_bad = 0, done_cnt = 0, err_cnt = 0, err_addr = 0;
    bit quiet = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            exp_addr = 0;
            nwords   = 0;
            skw      = 0;
        end else begin
            if (start_seen) quiet = 1'b0;
            if (ee_clk) skw++;
            else if (skw != 0) begin
                if (skw != HALF) skw_bad++;
                skw = 0;
            end
            if (quiet && (ee_sel || ee_clk || ee_mosi || word_valid || word_addr != 0 ||
                          word_data != 0 || done || error)) idle_bad++;
            if (word_valid) begin
                if (word_addr != 6'(exp_addr) || word_data != mem_word(exp_addr)) word_bad++;
                exp_addr++;
                nwords++;
            end
            if (done || error) begin
                run_words = nwords;
                nwords    = 0;
                exp_addr  = 0;
                if (done) done_cnt++;
                if (error) begin
                    err_cnt++;
                    err_addr = int'(word_addr);
                end
                if (!start_seen) quiet = 1'b1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        int d0, e0;
        d0 = done_cnt;
        e0 = err_cnt;
        while (done_cnt == d0 && err_cnt == e0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    typedef struct packed {
        bit inj;
        int addr;
        int words;
        bit err;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 0,  64, 1'b0},
        '{1'b1, 0,  0,  1'b1},
        '{1'b1, 37, 37, 1'b1},
        '{1'b1, 63, 63, 1'b1}
    };

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!ee_sel && !ee_clk && !ee_mosi, "R1 pins low in reset", {ee_sel, ee_clk, ee_mosi}, 0);
        check(!word_valid && !done && !error && word_addr == 0 && word_data == 0,
              "R1 strobes low in reset", {word_valid, done, error}, 0);
        @(negedge clk) rst = 1'b0;
        repeat (5) @(negedge clk);
        check(!ee_sel && !ee_clk && !ee_mosi && !done && !error, "R1 idle after reset",
              {ee_sel, ee_clk, ee_mosi, done, error}, 0);

        // R1: reset during a pass
        pulse_start();
        repeat (500) @(negedge clk);
        check(ee_sel, "R1 pass running before reset", ee_sel, 1);
        rst = 1'b1;
        @(negedge clk);
        check(!ee_sel && !ee_clk && !ee_mosi, "R1 mid-pass reset stops pins",
              {ee_sel, ee_clk, ee_mosi}, 0);
        @(negedge clk) rst = 1'b0;
        repeat (10) @(negedge clk);

        // table of passes
        for (int i = 0; i < 4; i++) begin
            int b_stop, b_cmd, b_seen, b_sess, b_skw, b_word, b_idle, b_done, b_err;
            inj_en   = VECS[i].inj;
            inj_addr = VECS[i].addr;
            b_stop = stop_cnt; b_cmd = cmd_bad; b_seen = cmd_seen; b_sess = sess_bad;
            b_skw = skw_bad; b_word = word_bad; b_idle = idle_bad;
            b_done = done_cnt; b_err = err_cnt;
            pulse_start();
            wait_end();
            check((err_cnt - b_err) == int'(VECS[i].err), "R4 error strobe", err_cnt - b_err, VECS[i].err);
            check((done_cnt - b_done) == int'(!VECS[i].err), "R7 done strobe", done_cnt - b_done, !VECS[i].err);
            check(run_words == VECS[i].words, "R7 words delivered", run_words, VECS[i].words);
            check(word_bad == b_word, "R5 word value and order", word_bad - b_word, 0);
            check(cmd_bad == b_cmd, "R2 command bits", cmd_bad - b_cmd, 0);
            check((cmd_seen - b_seen) == VECS[i].words + int'(VECS[i].err),
                  "R6 one command per word", cmd_seen - b_seen, VECS[i].words + int'(VECS[i].err));
            check((stop_cnt - b_stop) == VECS[i].words, "R6 trailing pulse with select low",
                  stop_cnt - b_stop, VECS[i].words);
            check(sess_bad == b_sess, "R6 select session length", sess_bad - b_sess, 0);
            check(skw_bad == b_skw, "R3 clock high width", skw_bad - b_skw, 0);
            if (VECS[i].err) check(err_addr == VECS[i].addr, "R4 failing address", err_addr, VECS[i].addr);
            repeat (40) @(negedge clk);
            check(idle_bad == b_idle, "R8 outputs idle after end", idle_bad - b_idle, 0);
        end
        inj_en = 1'b0;

        // R9: start during a pass is ignored
        begin
            int b_word, b_seen, b_done;
            b_word = word_bad; b_seen = cmd_seen; b_done = done_cnt;
            pulse_start();
            repeat (3000) @(negedge clk);
            pulse_start();
            wait_end();
            check(run_words == NW, "R9 pass length with extra start", run_words, NW);
            check(word_bad == b_word, "R9 order kept with extra start", word_bad - b_word, 0);
            check(cmd_seen - b_seen == NW, "R9 command count", cmd_seen - b_seen, NW);
            check(done_cnt - b_done == 1, "R9 single done", done_cnt - b_done, 1);
        end

        // R10: start held through done restarts at once
        begin
            int b_word;
            b_word = word_bad;
            repeat (10) @(negedge clk);
            @(negedge clk) start = 1'b1;
            do @(negedge clk); while (!done);
            check(!ee_sel, "R10 select low in done cycle", ee_sel, 0);
            @(negedge clk);
            check(ee_sel, "R10 select high after done", ee_sel, 1);
            start = 1'b0;
            wait_end();
            check(run_words == NW, "R10 second pass length", run_words, NW);
            check(word_bad == b_word, "R10 second pass from address 0", word_bad - b_word, 0);
            repeat (20) @(negedge clk);
            check(!ee_sel && !ee_clk && !ee_mosi, "R8 idle after second pass",
                  {ee_sel, ee_clk, ee_mosi}, 0);
        end

        report();
        $finish;
    end

endmodule